// File: doc/BRIEF.md
# Core Monitor and Dispatch Sequencer

This block sits between a process scheduler and a set of processor cores. It keeps a live working state for every core, takes one ready process per cycle (a process id and a start address) from the scheduler, and places it on a free core. For the chosen core it then runs a short launch sequence: one cycle of core reset, then one cycle of core init with the start address on a shared address bus. After that the core is marked as running.

When a running core raises its finish line, the block turns the event into a completion notice that carries the id of the process that core was running, and the core index. The scheduler uses these notices to release dependent work. If several cores finish together, the notices come out one per cycle. A core stays busy until its notice has been reported, and only then can it be chosen again. A ready process is taken in the same cycle it is offered, and its init cycle follows two cycles later. The whole path from offer to a launched core therefore fits well inside four cycles.

Top module: `core_dispatch_monitor`

## Requirements
- R1: After reset every core is idle: core_busy, core_rst, core_init and cmpl_valid are all zero, core_start_addr is zero, and rdy_accept is 1.
- R2: rdy_accept is 1 exactly when at least one core is idle. A ready process offered while rdy_accept is 0 is not taken: no core_rst bit rises in the following cycle.
- R3: When several cores are idle, the process goes to the lowest-numbered idle core (bit 0 of each per-core vector is core 0).
- R4: In the cycle after a process is taken (rdy_valid and rdy_accept both 1 at a clock edge), the chosen core's core_rst bit is 1 for exactly one cycle.
- R5: In the cycle after the reset pulse, that core's core_init bit is 1 for one cycle and core_start_addr carries the accepted start address. In every cycle with no init bit set, core_start_addr is zero.
- R6: A core's core_busy bit goes to 1 in the cycle after it is chosen and stays 1 until its completion notice has been reported.
- R7: A core_done pulse from a running core gives, in the next cycle, cmpl_valid = 1 with cmpl_pid equal to the id launched on that core and cmpl_core equal to its index. The core is idle in the cycle after the notice.
- R8: When several running cores finish in the same cycle, their notices come out on consecutive cycles, lowest core index first, each core staying busy until its own notice.
- R9: core_done is ignored for a core that is idle or still in its reset or init cycle: no notice appears and core_busy is unchanged.
- R10: Processes offered on consecutive cycles are taken on consecutive cycles by different cores, and their reset and init pulses overlap in a staggered way with no clash on core_start_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rdy_valid | input | 1 | A ready process is offered |
| rdy_pid | input | PID_W | Id of the offered process |
| rdy_addr | input | ADDR_W | Start address of the offered process |
| rdy_accept | output | 1 | The offered process is taken at this edge (some core idle) |
| core_done | input | NUM_CORES | Per-core finish pulse |
| core_rst | output | NUM_CORES | Per-core reset pulse of the launch sequence |
| core_init | output | NUM_CORES | Per-core init pulse of the launch sequence |
| core_start_addr | output | ADDR_W | Start address, valid with a core_init bit |
| core_busy | output | NUM_CORES | Per-core working state, 1 when not idle |
| cmpl_valid | output | 1 | A completion notice is presented |
| cmpl_pid | output | PID_W | Id of the completed process |
| cmpl_core | output | CORE_IDX_W | Index of the core that finished |

## Verification
A core whose state is wrong shows up within one cycle at the ports. A slot stuck busy lowers rdy_accept or moves the next launch to a higher core. A slot wrongly idle gets a second launch while still running. A lost process id appears as a wrong cmpl_pid on that core's next finish. Ordering faults show as a reset pulse without an init pulse one cycle later, an address present outside an init cycle, two notices in the wrong order, or a notice produced by a finish pulse that arrived during launch.

// File: rtl/cdm_pkg.sv
package cdm_pkg;

   typedef enum logic [2:0] {
      SLOT_IDLE = 3'd0,
      SLOT_RST  = 3'd1,
      SLOT_INIT = 3'd2,
      SLOT_RUN  = 3'd3,
      SLOT_DONE = 3'd4
   } slot_state_e;

endpackage

// File: rtl/cdm_lowest_pick.sv
module cdm_lowest_pick #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);

   if (N < 1) begin : g_bad_n
      $error("cdm_lowest_pick: N must be at least 1");
   end

   if (N == 1) begin : g_single
      assign grant = req;
      assign idx   = '0;
   end else begin : g_multi
      always_comb begin
         grant = '0;
         idx   = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
               grant    = '0;
               grant[i] = 1'b1;
               idx      = IW'(i);
            end
         end
      end
   end

   assign any = |req;

   always_comb begin
      assert_grant_onehot_R3: assert ($onehot0(grant));
   end

endmodule

// File: rtl/cdm_core_slot.sv
module cdm_core_slot
   import cdm_pkg::*;
#(
   parameter int PID_W  = 4,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [PID_W-1:0]  launch_pid,
   input  logic [ADDR_W-1:0] launch_addr,
   input  logic              done_in,
   input  logic              report,
   output logic              idle,
   output logic              rst_o,
   output logic              init_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              pending,
   output logic [PID_W-1:0]  pid_o
);

   slot_state_e       state;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SLOT_IDLE;
         pid_o  <= '0;
         addr_q <= '0;
      end else begin
         case (state)
            SLOT_IDLE: if (launch) begin
               state  <= SLOT_RST;
               pid_o  <= launch_pid;
               addr_q <= launch_addr;
            end
            SLOT_RST:  state <= SLOT_INIT;
            SLOT_INIT: state <= SLOT_RUN;
            SLOT_RUN:  if (done_in) state <= SLOT_DONE;
            SLOT_DONE: if (report)  state <= SLOT_IDLE;
            default:   state <= SLOT_IDLE;
         endcase
      end
   end

   assign idle    = (state == SLOT_IDLE);
   assign rst_o   = (state == SLOT_RST);
   assign init_o  = (state == SLOT_INIT);
   assign pending = (state == SLOT_DONE);
   assign addr_o  = init_o ? addr_q : '0;

   assert_launch_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> idle);
   assert_rst_then_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o |=> init_o);
   assert_rst_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o |=> !rst_o);
   assert_report_only_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      report |-> pending);
   assert_pending_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pending && !report |=> pending);
   assert_done_ignored_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      idle && done_in && !launch |=> idle);

endmodule

// File: rtl/core_dispatch_monitor.sv
module core_dispatch_monitor #(
   parameter int NUM_CORES  = 4,
   parameter int PID_W      = 4,
   parameter int ADDR_W     = 16,
   localparam int CORE_IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rdy_valid,
   input  logic [PID_W-1:0]      rdy_pid,
   input  logic [ADDR_W-1:0]     rdy_addr,
   output logic                  rdy_accept,
   input  logic [NUM_CORES-1:0]  core_done,
   output logic [NUM_CORES-1:0]  core_rst,
   output logic [NUM_CORES-1:0]  core_init,
   output logic [ADDR_W-1:0]     core_start_addr,
   output logic [NUM_CORES-1:0]  core_busy,
   output logic                  cmpl_valid,
   output logic [PID_W-1:0]      cmpl_pid,
   output logic [CORE_IDX_W-1:0] cmpl_core
);

   if (NUM_CORES < 1) begin : g_bad_cores
      $error("core_dispatch_monitor: NUM_CORES must be at least 1");
   end
   if (PID_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("core_dispatch_monitor: PID_W and ADDR_W must be at least 1");
   end

   logic [NUM_CORES-1:0]  slot_idle;
   logic [NUM_CORES-1:0]  slot_pending;
   logic [NUM_CORES-1:0]  sel_grant;
   logic [NUM_CORES-1:0]  cmp_grant;
   logic [NUM_CORES-1:0]  launch;
   logic [CORE_IDX_W-1:0] sel_idx;
   logic                  sel_any;
   logic [ADDR_W-1:0]     slot_addr [NUM_CORES];
   logic [PID_W-1:0]      slot_pid  [NUM_CORES];

   cdm_lowest_pick #(.N(NUM_CORES)) i_sel_pick (
      .req   (slot_idle),
      .grant (sel_grant),
      .idx   (sel_idx),
      .any   (sel_any)
   );

   cdm_lowest_pick #(.N(NUM_CORES)) i_cmp_pick (
      .req   (slot_pending),
      .grant (cmp_grant),
      .idx   (cmpl_core),
      .any   (cmpl_valid)
   );

   assign rdy_accept = sel_any;
   assign launch     = rdy_valid ? sel_grant : '0;

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
      cdm_core_slot #(.PID_W(PID_W), .ADDR_W(ADDR_W)) i_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .launch      (launch[c]),
         .launch_pid  (rdy_pid),
         .launch_addr (rdy_addr),
         .done_in     (core_done[c]),
         .report      (cmp_grant[c]),
         .idle        (slot_idle[c]),
         .rst_o       (core_rst[c]),
         .init_o      (core_init[c]),
         .addr_o      (slot_addr[c]),
         .pending     (slot_pending[c]),
         .pid_o       (slot_pid[c])
      );
   end

   assign core_busy = ~slot_idle;

   always_comb begin
      core_start_addr = '0;
      for (int c = 0; c < NUM_CORES; c++) begin
         core_start_addr = core_start_addr | slot_addr[c];
      end
   end

   assign cmpl_pid = slot_pid[cmpl_core];

   // sel_idx is kept for the checks below
   assert_take_one_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_valid && rdy_accept |=> $countones(core_rst) == 1);
   assert_taken_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_valid && rdy_accept |=> core_rst[$past(sel_idx)]);
   assert_refused_no_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_valid && !rdy_accept |=> core_rst == '0);
   assert_rst_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(core_rst));
   assert_init_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(core_init));
   assert_addr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      core_init == '0 |-> core_start_addr == '0);
   assert_freed_after_notice_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_valid |=> !core_busy[$past(cmpl_core)]);

endmodule

// File: tb/test_core_dispatch_monitor.sv
`timescale 1ns/1ps
module test_core_dispatch_monitor;

   localparam int N  = 4;
   localparam int PW = 4;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rdy_valid = 1'b0;
   logic [PW-1:0] rdy_pid = '0;
   logic [AW-1:0] rdy_addr = '0;
   logic          rdy_accept;
   logic [N-1:0]  core_done = '0;
   logic [N-1:0]  core_rst;
   logic [N-1:0]  core_init;
   logic [AW-1:0] core_start_addr;
   logic [N-1:0]  core_busy;
   logic          cmpl_valid;
   logic [PW-1:0] cmpl_pid;
   logic [1:0]    cmpl_core;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   core_dispatch_monitor #(.NUM_CORES(N), .PID_W(PW), .ADDR_W(AW)) i_core_dispatch_monitor (
      .clk, .rst_n, .rdy_valid, .rdy_pid, .rdy_addr, .rdy_accept,
      .core_done, .core_rst, .core_init, .core_start_addr, .core_busy,
      .cmpl_valid, .cmpl_pid, .cmpl_core
   );

   // {pid, start address, expected core}
   localparam logic [21:0] VEC [4] = '{
      {4'd5,  16'h1000, 2'd0},
      {4'd9,  16'h2040, 2'd1},
      {4'd3,  16'h3abc, 2'd2},
      {4'd12, 16'hfff0, 2'd3}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic eq(input string req, input string what, input longint act, input longint exp);
      chk(act == exp, req, what, act, exp);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      eq("R1", "busy", core_busy, 0);
      eq("R1", "rst", core_rst, 0);
      eq("R1", "init", core_init, 0);
      eq("R1", "cmpl_valid", cmpl_valid, 0);
      eq("R1", "addr", core_start_addr, 0);
      eq("R1", "accept", rdy_accept, 1);

      // table walk: fill all cores one at a time
      for (int v = 0; v < 4; v++) begin
         logic [3:0]  p;
         logic [15:0] a;
         logic [1:0]  c;
         {p, a, c} = VEC[v];
         step(); rdy_valid = 1'b1; rdy_pid = p; rdy_addr = a;
         #1 eq("R2", "accept with idle core", rdy_accept, 1);
         step(); rdy_valid = 1'b0;
         #1 eq("R3", "rst on lowest idle", core_rst, 4'b1 << c);
         eq("R4", "no init yet", core_init, 0);
         eq("R6", "busy set", core_busy[c], 1);
         step();
         #1 eq("R4", "rst single cycle", core_rst, 0);
         eq("R5", "init after rst", core_init, 4'b1 << c);
         eq("R5", "start addr", core_start_addr, a);
         step();
         #1 eq("R5", "init done", core_init, 0);
         eq("R5", "addr quiet", core_start_addr, 0);
      end

      // all busy: offer is refused
      step(); rdy_valid = 1'b1; rdy_pid = 4'd7; rdy_addr = 16'h0777;
      #1 eq("R2", "accept when all busy", rdy_accept, 0);
      step(); rdy_valid = 1'b0;
      #1 eq("R2", "refused offer not taken", core_rst, 0);
      eq("R6", "all busy", core_busy, 4'b1111);

      // single completion on core 2
      step(); core_done = 4'b0100;
      #1 eq("R7", "no notice before edge", cmpl_valid, 0);
      step(); core_done = 4'b0000;
      #1 eq("R7", "notice valid", cmpl_valid, 1);
      eq("R7", "notice pid", cmpl_pid, 3);
      eq("R7", "notice core", cmpl_core, 2);
      eq("R6", "busy until reported", core_busy[2], 1);
      step();
      #1 eq("R7", "notice gone", cmpl_valid, 0);
      eq("R7", "core 2 idle", core_busy, 4'b1011);

      // simultaneous completions on cores 1 and 3
      step(); core_done = 4'b1010;
      step(); core_done = 4'b0000;
      #1 eq("R8", "first notice core", cmpl_core, 1);
      eq("R8", "first notice pid", cmpl_pid, 9);
      eq("R8", "first notice valid", cmpl_valid, 1);
      step();
      #1 eq("R8", "second notice core", cmpl_core, 3);
      eq("R8", "second notice pid", cmpl_pid, 12);
      eq("R8", "core 3 busy until its notice", core_busy, 4'b1001);
      step();
      #1 eq("R8", "notices drained", cmpl_valid, 0);
      eq("R8", "busy after drain", core_busy, 4'b0001);

      // back-to-back offers with cores 1,2,3 idle
      step(); rdy_valid = 1'b1; rdy_pid = 4'd4; rdy_addr = 16'h0111;
      #1 eq("R10", "accept first", rdy_accept, 1);
      step(); rdy_pid = 4'd8; rdy_addr = 16'h0222;
      #1 eq("R3", "lowest idle is core 1", core_rst, 4'b0010);
      eq("R10", "accept second", rdy_accept, 1);
      step(); rdy_valid = 1'b0;
      #1 eq("R10", "second rst on core 2", core_rst, 4'b0100);
      eq("R10", "first init on core 1", core_init, 4'b0010);
      eq("R10", "first addr", core_start_addr, 16'h0111);
      step();
      #1 eq("R10", "second init on core 2", core_init, 4'b0100);
      eq("R10", "second addr", core_start_addr, 16'h0222);
      eq("R10", "rst quiet", core_rst, 0);

      // finish pulse on an idle core is ignored
      step(); core_done = 4'b1000;
      step(); core_done = 4'b0000;
      #1 eq("R9", "no notice from idle core", cmpl_valid, 0);
      eq("R9", "idle core stays idle", core_busy, 4'b0111);

      // finish pulses during reset and init cycles are ignored
      step(); rdy_valid = 1'b1; rdy_pid = 4'd2; rdy_addr = 16'h0333;
      step(); rdy_valid = 1'b0; core_done = 4'b1000;
      #1 eq("R9", "launch on core 3", core_rst, 4'b1000);
      step(); core_done = 4'b1000;
      #1 eq("R9", "no notice during rst", cmpl_valid, 0);
      step(); core_done = 4'b0000;
      #1 eq("R9", "no notice during init", cmpl_valid, 0);
      step();
      #1 eq("R9", "still no notice", cmpl_valid, 0);
      eq("R9", "core 3 still busy", core_busy, 4'b1111);

      // real finish on core 3 carries its latched id
      step(); core_done = 4'b1000;
      step(); core_done = 4'b0000;
      #1 eq("R7", "relaunched pid", cmpl_pid, 2);
      eq("R7", "relaunched core", cmpl_core, 3);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #20000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule